// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits beside a processor core and handles the moment when one or more exceptional events are raised together. Seven request lines come in: a system reset, a data-side abort, a fast interrupt, a normal interrupt, an instruction-fetch abort, an unknown-instruction trap and a supervisor-call trap. The block also sees the current 32-bit status word and the address of the instruction in flight. Each cycle it drops any interrupt whose mask bit in the status word is set, and picks one winner among what remains by a fixed ranking.

For the winner it prepares the entry step in a single registered cycle. It pulses a take strobe, presents the handler address, builds the status word the core is to load (new mode, raised mask bits, instruction-set state bit cleared, flags kept), hands back an untouched copy of the old status word for the mode's saved-status register, and gives the link value. Decode, pipeline, register file and return-from-handler are outside the block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Winner ranking from highest to lowest: reset, data abort, fast interrupt, normal interrupt, fetch abort, then unknown-instruction and supervisor-call at the lowest level. Reset wins whenever it is raised.
- R2: Handler addresses are 0x00 reset, 0x04 unknown instruction, 0x08 supervisor call, 0x0C fetch abort, 0x10 data abort, 0x18 normal interrupt, 0x1C fast interrupt; 0x14 is never produced.
- R3: A normal interrupt counts only while status bit 7 (I) is 0; a fast interrupt counts only while status bit 6 (F) is 0. A masked request lets the next lower accepted request win, or none.
- R4: New status bits [4:0] hold the mode: 10011 for reset and supervisor call, 10111 for both aborts, 11011 for unknown instruction, 10010 for normal interrupt, 10001 for fast interrupt.
- R5: New status bit 7 (I) is set on every entry; bit 6 (F) is set for reset and fast interrupt and copied from the input status otherwise.
- R6: New status bit 5 (instruction-set state) is cleared on every entry; bits [31:8] are copied from the input status.
- R7: The saved status equals the input status; the link value is the instruction address plus 8 for data abort and plus 4 for every other non-reset exception; for reset both are 0.
- R8: Outputs are registered: take is 1 in the cycle after a cycle with an accepted request and 0 after a cycle without one; with take at 0 all other outputs are 0.
- R9: When unknown-instruction and supervisor-call requests are raised together with nothing higher, the unknown-instruction entry is taken.
- R10: While the block's reset input is low, take and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| req_rst_i | input | 1 | System reset exception request |
| req_dabt_i | input | 1 | Data abort request |
| req_fast_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_pabt_i | input | 1 | Fetch abort request |
| req_und_i | input | 1 | Unknown-instruction request |
| req_swi_i | input | 1 | Supervisor-call request |
| stat_i | input | 32 | Current status word |
| pc_i | input | ADDR_W | Address of the current instruction |
| take_o | output | 1 | One-cycle entry strobe |
| vec_o | output | ADDR_W | Handler address |
| stat_o | output | 32 | Status word to load on entry |
| saved_o | output | 32 | Copy of the status word to save |
| link_o | output | ADDR_W | Value for the link register |

## Verification
Every result is due exactly one clock after the edge that samples the requests, status and address, since a single register stage sits between arbitration and the ports. The bench changes inputs on the falling edge, lets one rising edge capture them, and compares all five outputs at the next falling edge before driving the following pattern, so each pattern is judged alone and a stale strobe shows up as a mismatch. The sweep covers all 128 request combinations under all four settings of the two mask bits, with the instruction-set bit, flags and address varied.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int STAT_W = 32;
  localparam int MODE_W = 5;
  localparam int BIT_I  = 7;
  localparam int BIT_F  = 6;
  localparam int BIT_T  = 5;
  localparam int NREQ   = 7;

  // request index = rank (0 is the highest)
  localparam int IX_RST  = 0;
  localparam int IX_DABT = 1;
  localparam int IX_FAST = 2;
  localparam int IX_IRQ  = 3;
  localparam int IX_PABT = 4;
  localparam int IX_UND  = 5;
  localparam int IX_SWI  = 6;

  typedef enum logic [2:0] {
    K_NONE, K_RST, K_DABT, K_FAST, K_IRQ, K_PABT, K_UND, K_SWI
  } exc_kind_e;

  function automatic logic [7:0] kind_vec(exc_kind_e k);
    case (k)
      K_UND:   return 8'h04;
      K_SWI:   return 8'h08;
      K_PABT:  return 8'h0C;
      K_DABT:  return 8'h10;
      K_IRQ:   return 8'h18;
      K_FAST:  return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] kind_mode(exc_kind_e k);
    case (k)
      K_FAST:         return 5'b10001;
      K_IRQ:          return 5'b10010;
      K_DABT, K_PABT: return 5'b10111;
      K_UND:          return 5'b11011;
      default:        return 5'b10011;
    endcase
  endfunction

  function automatic logic [3:0] kind_link_off(exc_kind_e k);
    case (k)
      K_NONE, K_RST: return 4'd0;
      K_DABT:        return 4'd8;
      default:       return 4'd4;
    endcase
  endfunction

  function automatic logic kind_sets_f(exc_kind_e k);
    return (k == K_RST) || (k == K_FAST);
  endfunction

endpackage

// File: rtl/exc_req_gate.sv
module exc_req_gate
  import exc_entry_pkg::*;
(
  input  logic [NREQ-1:0]   req_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [NREQ-1:0]   acc_o,
  output logic              any_o
);
  always_comb begin
    acc_o          = req_i;
    acc_o[IX_FAST] = req_i[IX_FAST] & ~stat_i[BIT_F];
    acc_o[IX_IRQ]  = req_i[IX_IRQ]  & ~stat_i[BIT_I];
    any_o          = |acc_o;
  end
endmodule

// File: rtl/exc_rank_pick.sv
module exc_rank_pick
  import exc_entry_pkg::*;
(
  input  logic [NREQ-1:0] acc_i,
  output logic [NREQ-1:0] grant_o,
  output exc_kind_e       kind_o
);
  assign grant_o[0] = acc_i[0];
  for (genvar g = 1; g < NREQ; g++) begin : g_rank
    assign grant_o[g] = acc_i[g] & ~|acc_i[g-1:0];
  end

  always_comb begin
    kind_o = K_NONE;
    if (grant_o[IX_RST])  kind_o = K_RST;
    if (grant_o[IX_DABT]) kind_o = K_DABT;
    if (grant_o[IX_FAST]) kind_o = K_FAST;
    if (grant_o[IX_IRQ])  kind_o = K_IRQ;
    if (grant_o[IX_PABT]) kind_o = K_PABT;
    if (grant_o[IX_UND])  kind_o = K_UND;
    if (grant_o[IX_SWI])  kind_o = K_SWI;
  end
endmodule

// File: rtl/exc_stat_build.sv
module exc_stat_build
  import exc_entry_pkg::*;
(
  input  exc_kind_e         kind_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0] stat_o
);
  always_comb begin
    stat_o               = stat_i;
    stat_o[MODE_W-1:0]   = kind_mode(kind_i);
    stat_o[BIT_T]        = 1'b0;
    stat_o[BIT_I]        = 1'b1;
    if (kind_sets_f(kind_i)) stat_o[BIT_F] = 1'b1;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rst_i,
  input  logic              req_dabt_i,
  input  logic              req_fast_i,
  input  logic              req_irq_i,
  input  logic              req_pabt_i,
  input  logic              req_und_i,
  input  logic              req_swi_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] saved_o,
  output logic [ADDR_W-1:0] link_o
);
  localparam logic [ADDR_W-1:0] RSVD_VEC = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] IRQ_VEC  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] FAST_VEC = ADDR_W'(8'h1C);

  logic [NREQ-1:0]   req_vec, acc_vec, grant_vec;
  logic              any_acc;
  exc_kind_e         win_kind;
  logic [STAT_W-1:0] built_stat;
  logic              live_q;

  always_comb begin
    req_vec          = '0;
    req_vec[IX_RST]  = req_rst_i;
    req_vec[IX_DABT] = req_dabt_i;
    req_vec[IX_FAST] = req_fast_i;
    req_vec[IX_IRQ]  = req_irq_i;
    req_vec[IX_PABT] = req_pabt_i;
    req_vec[IX_UND]  = req_und_i;
    req_vec[IX_SWI]  = req_swi_i;
  end

  exc_req_gate u_gate (
    .req_i (req_vec),
    .stat_i(stat_i),
    .acc_o (acc_vec),
    .any_o (any_acc)
  );

  exc_rank_pick u_pick (
    .acc_i  (acc_vec),
    .grant_o(grant_vec),
    .kind_o (win_kind)
  );

  exc_stat_build u_build (
    .kind_i(win_kind),
    .stat_i(stat_i),
    .stat_o(built_stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o  <= 1'b0;
      vec_o   <= '0;
      stat_o  <= '0;
      saved_o <= '0;
      link_o  <= '0;
      live_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (win_kind != K_NONE) begin
        take_o <= 1'b1;
        vec_o  <= ADDR_W'(kind_vec(win_kind));
        stat_o <= built_stat;
        if (win_kind == K_RST) begin
          saved_o <= '0;
          link_o  <= '0;
        end else begin
          saved_o <= stat_i;
          link_o  <= pc_i + ADDR_W'(kind_link_off(win_kind));
        end
      end else begin
        take_o  <= 1'b0;
        vec_o   <= '0;
        stat_o  <= '0;
        saved_o <= '0;
        link_o  <= '0;
      end
    end
  end

  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  a_r1_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(req_rst_i)) |->
      (take_o && vec_o == '0 && saved_o == '0 && link_o == '0));

  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_o != RSVD_VEC));

  a_r3_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && take_o && vec_o == IRQ_VEC) |-> !$past(stat_i[BIT_I]));

  a_r3_fast_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && take_o && vec_o == FAST_VEC) |-> !$past(stat_i[BIT_F]));

  a_r5_i_raised: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> stat_o[BIT_I]);

  a_r6_state_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !stat_o[BIT_T]);

  a_r8_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(any_acc)) |-> (!take_o && vec_o == '0 && stat_o == '0));

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic r_rst, r_dabt, r_fast, r_irq, r_pabt, r_und, r_swi;
  logic [31:0] stat;
  logic [AW-1:0] pc;
  logic take;
  logic [AW-1:0] vec, link;
  logic [31:0] nstat, saved;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_entry_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_rst_i(r_rst), .req_dabt_i(r_dabt), .req_fast_i(r_fast),
    .req_irq_i(r_irq), .req_pabt_i(r_pabt), .req_und_i(r_und),
    .req_swi_i(r_swi), .stat_i(stat), .pc_i(pc),
    .take_o(take), .vec_o(vec), .stat_o(nstat), .saved_o(saved),
    .link_o(link)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model: r bit0 rst,1 dabt,2 fast,3 irq,4 pabt,5 und,6 swi
  task automatic apply(input logic [6:0] r, input logic [31:0] s, input logic [31:0] a);
    logic [31:0] e_vec, e_stat, e_saved, e_link;
    logic [4:0]  mode;
    logic        e_take, setf;
    int          off;
    {r_swi, r_und, r_pabt, r_irq, r_fast, r_dabt, r_rst} = r;
    stat = s;
    pc   = a;
    e_take = 1'b1; setf = 1'b0; off = 4; mode = 5'b10011; e_vec = 0;
    if (r[0])                 begin e_vec = 32'h00; setf = 1'b1; off = 0; end // R1 reset first
    else if (r[1])            begin e_vec = 32'h10; mode = 5'b10111; off = 8; end
    else if (r[2] && !s[6])   begin e_vec = 32'h1C; mode = 5'b10001; setf = 1'b1; end // R3 F gate
    else if (r[3] && !s[7])   begin e_vec = 32'h18; mode = 5'b10010; end // R3 I gate
    else if (r[4])            begin e_vec = 32'h0C; mode = 5'b10111; end
    else if (r[5])            begin e_vec = 32'h04; mode = 5'b11011; end // R9 und over swi
    else if (r[6])            begin e_vec = 32'h08; mode = 5'b10011; end
    else e_take = 1'b0;
    e_stat  = {s[31:8], 1'b1, setf | s[6], 1'b0, mode};
    e_saved = r[0] ? 32'h0 : s;
    e_link  = r[0] ? 32'h0 : a + 32'(off);
    if (!e_take) begin e_stat = 0; e_saved = 0; e_link = 0; end
    @(negedge clk);
    chk("R8 take", {31'b0, take}, {31'b0, e_take});
    chk((r[6:5] == 2'b11) ? "R9 R2 vec" : "R1 R2 vec", vec, e_vec);
    chk("R4 R5 R6 status", nstat, e_stat);
    chk("R7 saved", saved, e_saved);
    chk("R7 link", link, e_link);
  endtask

  initial begin
    rst_n = 1'b0;
    {r_swi, r_und, r_pabt, r_irq, r_fast, r_dabt, r_rst} = 7'h7F;
    stat = 32'hF000_0010;
    pc = 32'h100;
    repeat (3) @(negedge clk);
    chk("R10 take", {31'b0, take}, 32'h0);
    chk("R10 vec", vec, 32'h0);
    chk("R10 status", nstat, 32'h0);
    chk("R10 link", link | saved, 32'h0);
    rst_n = 1'b1;
    {r_swi, r_und, r_pabt, r_irq, r_fast, r_dabt, r_rst} = 7'h0;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 128; r++) begin
        logic [31:0] s;
        s = {4'(r ^ m), 20'h5A3C1 ^ 20'(r * 37), m[1], m[0], r[0], 5'b10000};
        apply(7'(r), s, 32'h4000_0000 + 32'(r * 4) + 32'(m * 32'h100));
      end
    end
    // R8 strobe drops straight after a single taken cycle
    apply(7'b0001000, 32'h0000_0010, 32'h200);
    apply(7'b0000000, 32'h0000_0010, 32'h204);
    // R9 both traps with a masked interrupt alongside
    apply(7'b1101000, 32'h0000_00D0, 32'h300);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule